// File: doc/BRIEF.md
# Floating-Point Exception Trap Unit

This unit watches the IEEE 754 exception flags raised by the lanes of one SIMD wavefront. Each cycle it merges the five flag bits of every enabled lane into one vector and ORs that vector into a sticky per-wavefront status. Running code reaches the status through three commands: set ORs a mask in, clear removes a mask, and get returns the current value.

A second five-bit input chooses a policy for each exception. With its bit clear, an exception is only recorded. With its bit set, the exception also traps. The wavefront is then halted and a one-cycle notification carrying the exception code goes to the host-side handler. The wavefront stays halted until the handler acknowledges.

Exception codes and status bit positions are: 0 invalid operation, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact. The controller has three states:
- `ST_RUN` is normal execution.
- `ST_NOTIFY` is the first halted cycle, which carries the notification.
- `ST_HALTED` is the wait for acknowledgement.

Its transitions are:
- `RUN->NOTIFY` when an enabled trapping flag is seen.
- `NOTIFY->HALTED` when there is no acknowledge.
- `NOTIFY->RUN` or `HALTED->RUN` when the acknowledge arrives.
- `HALTED->HALTED` while waiting.

Top module: `fpx_trap_unit`

## Requirements
- R1: After reset the status is 0, `halt`, `notify_valid` and `rd_valid` are 0, and the controller is in `ST_RUN`.
- R2: Lane i drives `lane_flags[5*i+4:5*i]`, with bit k meaning exception code k. Only lanes whose `lane_en` bit is 1 reach the status; flags on disabled lanes have no effect.
- R3: A status bit, once set, stays set through any number of idle cycles until a clear command removes it.
- R4: Command code 1 (set) ORs `cmd_mask` into the status.
- R5: Command code 2 (clear) removes the bits of `cmd_mask` from the status.
- R6: Command code 3 (get) makes `rd_valid` 1 in the next cycle, with `rd_status` equal to the status as it stood in the command cycle. Command code 0 does nothing.
- R7: When a clear and a merged hardware flag hit the same bit in the same cycle, the bit ends up set.
- R8: A flag whose `brk_policy` bit is 0 never asserts `halt` or `notify_valid`.
- R9: An enabled flag whose `brk_policy` bit is 1, seen in `ST_RUN`, makes `halt` and `notify_valid` 1 in the next cycle. `notify_valid` lasts exactly one cycle.
- R10: When several trapping exceptions arrive in one cycle, `notify_code` is the lowest of their codes.
- R11: `halt` stays 1 until `handler_ack` is 1, and is 0 in the cycle after the acknowledge.
- R12: Trapping flags that arrive while halted are recorded in the status but give no further notification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_en | input | LANES | Active-lane mask |
| lane_flags | input | 5*LANES | Per-lane exception flags, five bits per lane |
| brk_policy | input | 5 | Per-exception trap policy, 1 = halt on it |
| cmd_op | input | 2 | 0 none, 1 set, 2 clear, 3 get |
| cmd_mask | input | 5 | Mask for set and clear |
| handler_ack | input | 1 | Handler acknowledge, releases halt |
| rd_status | output | 5 | Status returned by get |
| rd_valid | output | 1 | `rd_status` valid pulse |
| halt | output | 1 | Wavefront halt request |
| notify_valid | output | 1 | One-cycle handler notification |
| notify_code | output | 3 | Exception code reported with the notification |

## Verification
The merge is driven with flags spread over lane 0, a middle lane and lane 63, with some lanes disabled. This separates a correct enable mask from an unmasked OR or a wrong lane slice.

The status path is exercised with:
- set and clear masks that overlap existing bits;
- a clear that collides with a hardware flag on the same bit;
- idle stretches between commands.

Together these tell stickiness apart from a status that decays, and show which source wins a collision. The trap path is driven with record-only flags, with several trapping flags in one cycle under different policy masks, and with flags arriving while halted. These cases expose wrong priority, repeated notification and early release.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int unsigned NUM_EXC = 5;
    localparam int unsigned CODE_W  = 3;

    typedef logic [NUM_EXC-1:0] exc_vec_t;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_SET   = 2'd1,
        CMD_CLEAR = 2'd2,
        CMD_GET   = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_NOTIFY = 2'd1,
        ST_HALTED = 2'd2
    } trap_state_e;
endpackage

// File: rtl/fpx_lane_merge.sv
module fpx_lane_merge
    import fpx_pkg::*;
#(
    parameter int unsigned LANES = 64
) (
    input  logic [LANES-1:0]         lane_en,
    input  logic [NUM_EXC*LANES-1:0] lane_flags,
    output exc_vec_t                 merged
);
    exc_vec_t gated [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign gated[g] = lane_flags[NUM_EXC*g +: NUM_EXC] & {NUM_EXC{lane_en[g]}};
    end

    always_comb begin
        merged = '0;
        for (int i = 0; i < LANES; i++) begin
            merged = merged | gated[i];
        end
    end
endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg
    import fpx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  exc_vec_t hw_flags,
    input  cmd_e     cmd_op,
    input  exc_vec_t cmd_mask,
    output exc_vec_t status_q,
    output exc_vec_t rd_status,
    output logic     rd_valid
);
    exc_vec_t set_m, clr_m, status_d;

    always_comb begin
        set_m    = (cmd_op == CMD_SET)   ? cmd_mask : '0;
        clr_m    = (cmd_op == CMD_CLEAR) ? cmd_mask : '0;
        // hardware flags are applied last so they win a collision
        status_d = ((status_q | set_m) & ~clr_m) | hw_flags;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q  <= '0;
            rd_status <= '0;
            rd_valid  <= 1'b0;
        end else begin
            status_q <= status_d;
            rd_valid <= (cmd_op == CMD_GET);
            if (cmd_op == CMD_GET) rd_status <= status_q;
        end
    end

    // R3: bits not cleared survive
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op != CMD_CLEAR) |=> (($past(status_q) & ~status_q) == '0));
    // R7: merged hardware flags always land
    p_hw_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_flags != '0) |=> (($past(hw_flags) & ~status_q) == '0));
    // R6: get answers exactly one cycle later
    p_get_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == CMD_GET) |=> (rd_valid && rd_status == $past(status_q)));
endmodule

// File: rtl/fpx_trap_ctrl.sv
module fpx_trap_ctrl
    import fpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  exc_vec_t          hw_flags,
    input  exc_vec_t          brk_policy,
    input  logic              handler_ack,
    output logic              halt,
    output logic              notify_valid,
    output logic [CODE_W-1:0] notify_code
);
    trap_state_e state_q, state_d;
    exc_vec_t          trap_hits;
    logic [CODE_W-1:0] low_code;
    logic [CODE_W-1:0] code_q;

    always_comb begin
        trap_hits = hw_flags & brk_policy;
        low_code  = '0;
        for (int k = NUM_EXC-1; k >= 0; k--) begin
            if (trap_hits[k]) low_code = CODE_W'(k);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (trap_hits != '0) state_d = ST_NOTIFY;
            ST_NOTIFY: state_d = handler_ack ? ST_RUN : ST_HALTED;
            ST_HALTED: if (handler_ack) state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && trap_hits != '0) code_q <= low_code;
        end
    end

    always_comb begin
        halt         = (state_q != ST_RUN);
        notify_valid = (state_q == ST_NOTIFY);
        notify_code  = code_q;
    end

    // R9: trapping flag in run halts next cycle
    p_halt_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && trap_hits != '0) |=> (halt && notify_valid));
    // R9: notification is a single pulse
    p_notify_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid |=> !notify_valid);
    // R8: record-only flags never halt from run
    p_detect_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && trap_hits == '0) |=> !halt);
    // R11: halt held until acknowledge
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !handler_ack) |=> halt);
    // R11: acknowledge releases
    p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && handler_ack) |=> !halt);
endmodule

// File: rtl/fpx_trap_unit.sv
module fpx_trap_unit
    import fpx_pkg::*;
#(
    parameter int unsigned LANES = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         lane_en,
    input  logic [NUM_EXC*LANES-1:0] lane_flags,
    input  logic [NUM_EXC-1:0]       brk_policy,
    input  logic [1:0]               cmd_op,
    input  logic [NUM_EXC-1:0]       cmd_mask,
    input  logic                     handler_ack,
    output logic [NUM_EXC-1:0]       rd_status,
    output logic                     rd_valid,
    output logic                     halt,
    output logic                     notify_valid,
    output logic [CODE_W-1:0]        notify_code
);
    exc_vec_t merged;
    exc_vec_t status_q;

    fpx_lane_merge #(.LANES(LANES)) u_merge (
        .lane_en    (lane_en),
        .lane_flags (lane_flags),
        .merged     (merged)
    );

    fpx_status_reg u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_flags  (merged),
        .cmd_op    (cmd_e'(cmd_op)),
        .cmd_mask  (cmd_mask),
        .status_q  (status_q),
        .rd_status (rd_status),
        .rd_valid  (rd_valid)
    );

    fpx_trap_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .hw_flags     (merged),
        .brk_policy   (brk_policy),
        .handler_ack  (handler_ack),
        .halt         (halt),
        .notify_valid (notify_valid),
        .notify_code  (notify_code)
    );

    // R12: a halted wavefront is never re-notified
    p_no_renotify_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !notify_valid) |=> (!notify_valid || !$past(halt)));
    // R1: notification only while halted
    p_notify_halted_r1: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid |-> halt);
endmodule

// File: tb/fpx_trap_unit_tb.sv
module fpx_trap_unit_tb;
    localparam int LANES = 64;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [LANES-1:0] lane_en;
    logic [5*LANES-1:0] lane_flags;
    logic [4:0]       brk_policy;
    logic [1:0]       cmd_op;
    logic [4:0]       cmd_mask;
    logic             handler_ack;
    logic [4:0]       rd_status;
    logic             rd_valid;
    logic             halt;
    logic             notify_valid;
    logic [2:0]       notify_code;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    fpx_trap_unit #(.LANES(LANES)) u_dut (
        .clk(clk), .rst_n(rst_n), .lane_en(lane_en), .lane_flags(lane_flags),
        .brk_policy(brk_policy), .cmd_op(cmd_op), .cmd_mask(cmd_mask),
        .handler_ack(handler_ack), .rd_status(rd_status), .rd_valid(rd_valid),
        .halt(halt), .notify_valid(notify_valid), .notify_code(notify_code)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_get(input string req, input logic [4:0] exp);
        cmd_op = 2'd3; tick(); cmd_op = 2'd0;
        chk({req, " rd_valid"}, {31'd0, rd_valid}, 1);
        chk({req, " rd_status"}, {27'd0, rd_status}, {27'd0, exp});
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic [4:0] m);
        cmd_op = op; cmd_mask = m; tick(); cmd_op = 2'd0; cmd_mask = '0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; lane_en = '0; lane_flags = '0; brk_policy = '0;
        cmd_op = '0; cmd_mask = '0; handler_ack = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1; tick();
        chk("R1 halt", {31'd0, halt}, 0);
        chk("R1 notify", {31'd0, notify_valid}, 0);
        chk("R1 rd_valid", {31'd0, rd_valid}, 0);
        do_get("R1 status", 5'b00000);
    endtask

    task automatic t_merge();
        lane_en = '0; lane_en[0] = 1'b1; lane_en[63] = 1'b1;
        lane_flags[5*5 +: 5]  = 5'b00001;
        lane_flags[5*63 +: 5] = 5'b00100;
        lane_flags[5*0 +: 5]  = 5'b10000;
        tick();
        lane_flags = '0;
        do_get("R2 merge", 5'b10100);
    endtask

    task automatic t_sticky_clear_set();
        repeat (6) tick();
        do_get("R3 sticky", 5'b10100);
        do_cmd(2'd2, 5'b00100);
        do_get("R5 clear", 5'b10000);
        do_cmd(2'd1, 5'b01010);
        do_get("R4 set", 5'b11010);
        do_cmd(2'd0, 5'b11111);
        do_get("R6 none", 5'b11010);
        do_cmd(2'd2, 5'b11111);
        do_get("R5 clear all", 5'b00000);
    endtask

    task automatic t_hw_wins();
        lane_en = '1;
        do_cmd(2'd1, 5'b00011);
        lane_flags[5*30 +: 5] = 5'b00001;
        do_cmd(2'd2, 5'b00011);
        lane_flags = '0;
        do_get("R7 hw wins", 5'b00001);
        do_cmd(2'd2, 5'b11111);
    endtask

    task automatic t_detect_only();
        brk_policy = 5'b00010;
        lane_flags[5*7 +: 5] = 5'b10101;
        tick();
        lane_flags = '0;
        chk("R8 halt", {31'd0, halt}, 0);
        tick();
        chk("R8 notify", {31'd0, notify_valid | halt}, 0);
        do_cmd(2'd2, 5'b11111);
    endtask

    task automatic t_break();
        brk_policy = 5'b11010;
        lane_flags[5*12 +: 5] = 5'b11010;
        tick();
        lane_flags = '0;
        chk("R9 halt", {31'd0, halt}, 1);
        chk("R9 notify", {31'd0, notify_valid}, 1);
        chk("R10 code", {29'd0, notify_code}, 1);
        tick();
        chk("R9 pulse", {31'd0, notify_valid}, 0);
        lane_flags[5*40 +: 5] = 5'b01000;
        tick();
        lane_flags = '0;
        tick();
        chk("R12 no renotify", {31'd0, notify_valid}, 0);
        repeat (4) tick();
        chk("R11 held", {31'd0, halt}, 1);
        do_get("R12 recorded", 5'b11010);
        handler_ack = 1'b1; tick(); handler_ack = 1'b0;
        chk("R11 release", {31'd0, halt}, 0);
        tick();
        chk("R11 stays run", {31'd0, halt}, 0);
    endtask

    task automatic t_priority();
        brk_policy = 5'b11111;
        lane_en = '0; lane_en[63] = 1'b1; lane_en[1] = 1'b1;
        lane_flags[5*63 +: 5] = 5'b10000;
        lane_flags[5*1 +: 5]  = 5'b00100;
        lane_flags[5*2 +: 5]  = 5'b00001;
        tick();
        lane_flags = '0;
        chk("R10 code2", {29'd0, notify_code}, 2);
        chk("R9 halt2", {31'd0, halt}, 1);
        handler_ack = 1'b1; tick(); handler_ack = 1'b0;
        chk("R11 ack in notify", {31'd0, halt}, 0);
    endtask

    initial begin
        t_reset();
        t_merge();
        t_sticky_clear_set();
        t_hw_wins();
        t_detect_only();
        t_break();
        t_priority();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule